// File: doc/BRIEF.md
# Serial Link Reset Sequencer

This block brings a transmit/receive serial link pair out of reset in a fixed order after a global reset. First it holds the transceiver reset controller in reset for a programmable number of system-clock cycles. It then waits for the transmit side of the transceiver to report ready and releases the transmit configuration reset. After that it releases the transmit link reset, aligned to the link clock. Only then does it accept the receive-side ready. It releases the receive configuration reset and the receive link reset in the same way.

When both link layers are running, the block emits one SYSREF pulse, one link-clock cycle wide. This pulse realigns the multiframe counters on both sides. A completion flag then rises. If either ready indication is lost, every managed reset is asserted again and the whole sequence starts over.

All resets are active low. They are asserted asynchronously and released synchronously. The ready inputs cross into the system-clock domain through multi-flop synchronisers before the state machine uses them.

Top module: `link_reset_seq`

## Requirements
- R1: While `glb_rst_n` is low, `xcvr_rst_n`, `tx_cfg_rst_n`, `tx_link_rst_n`, `rx_cfg_rst_n`, `rx_link_rst_n`, `sysref` and `seq_done` are all 0, and they drop without waiting for a clock edge.
- R2: After `glb_rst_n` rises, `xcvr_rst_n` stays 0 for at least `DLY_CYC` rising edges of `sys_clk`, and then goes to 1.
- R3: `tx_cfg_rst_n` goes to 1 only after `xcvr_rst_n` is 1 and a synchronised `tx_ready` of 1 has been seen. It stays 0 for as long as `tx_ready` stays 0.
- R4: With `LINK_STAGES`=1, `tx_link_rst_n` goes to 1 on the first rising edge of `link_clk` at which `tx_cfg_rst_n` is 1. It drops at once when `tx_cfg_rst_n` drops.
- R5: `rx_cfg_rst_n` goes to 1 only while `tx_cfg_rst_n` is 1 and a synchronised `rx_ready` of 1 has been seen. An `rx_ready` that is already 1 before `tx_ready` does not advance the receive side early.
- R6: With `LINK_STAGES`=1, `rx_link_rst_n` goes to 1 on the first rising edge of `link_clk` at which `rx_cfg_rst_n` is 1. It drops at once when `rx_cfg_rst_n` drops.
- R7: After both link resets are 1, exactly one `sysref` pulse is produced. It is one `link_clk` cycle wide, and `sysref` is 1 only while both link resets are 1.
- R8: `seq_done` rises on the `link_clk` edge after the `sysref` pulse. It stays 1 until a global reset or a restart.
- R9: If `tx_ready` or `rx_ready` drops after the configuration stage it gates has been passed, all managed resets go back to 0 and `seq_done` clears. The full sequence, including the delay and a new single `sysref` pulse, runs again once the ready inputs return.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | System clock for the sequencing state machine |
| link_clk | input | 1 | Link clock; link resets and SYSREF are timed to it |
| glb_rst_n | input | 1 | Asynchronous global reset, active low |
| tx_ready | input | 1 | Transmit transceiver ready (asynchronous) |
| rx_ready | input | 1 | Receive transceiver ready (asynchronous) |
| xcvr_rst_n | output | 1 | Reset to the transceiver reset controller, active low |
| tx_cfg_rst_n | output | 1 | Transmit configuration-interface reset, active low |
| tx_link_rst_n | output | 1 | Transmit link-layer reset, active low, link_clk aligned |
| rx_cfg_rst_n | output | 1 | Receive configuration-interface reset, active low |
| rx_link_rst_n | output | 1 | Receive link-layer reset, active low, link_clk aligned |
| sysref | output | 1 | Single-cycle alignment pulse in the link_clk domain |
| seq_done | output | 1 | Sequence complete, link_clk domain |

## Verification
The bring-up is driven with three orders of the ready inputs. In the first, transmit ready arrives well before receive ready. In the second, receive ready is raised first, which shows whether the receive stage honours its dependency on the transmit stage. In the third, a ready input is withdrawn after completion, which separates a real restart (delay, fresh pulse) from a design that only clears its flags. A global reset applied in mid-sequence shows whether the resets assert asynchronously. A monitor on every link-clock edge compares each link reset with the configuration reset seen just before that edge and counts every SYSREF pulse. It therefore catches both late release and extra pulses.

// File: rtl/lrs_pkg.sv
package lrs_pkg;
   typedef enum logic [1:0] {
      ST_DELAY = 2'd0,
      ST_TXW   = 2'd1,
      ST_RXW   = 2'd2,
      ST_UP    = 2'd3
   } seq_state_t;
endpackage

// File: rtl/lrs_sync.sv
module lrs_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   if (STAGES < 1) begin : g_bad_stages
      $error("lrs_sync: STAGES must be at least 1");
   end

   if (STAGES == 1) begin : g_one
      logic q_r;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) q_r <= 1'b0;
         else        q_r <= d;
      end
      assign q = q_r;
   end else begin : g_chain
      logic [STAGES-1:0] sr;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sr <= '0;
         else        sr <= {sr[STAGES-2:0], d};
      end
      assign q = sr[STAGES-1];
   end
endmodule

// File: rtl/lrs_fsm.sv
module lrs_fsm
   import lrs_pkg::*;
#(
   parameter int DLY_CYC = 5
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tx_s,
   input  logic rx_s,
   output logic xcvr_rst_n,
   output logic tx_cfg_rst_n,
   output logic rx_cfg_rst_n
);
   localparam int CNT_W = $clog2(DLY_CYC + 1);
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DLY_CYC - 1);

   seq_state_t       state, nxt;
   logic [CNT_W-1:0] cnt;
   logic             xcvr_q, tx_cfg_q, rx_cfg_q;

   always_comb begin
      nxt = state;
      unique case (state)
         ST_DELAY: if (cnt == CNT_LAST) nxt = ST_TXW;
         ST_TXW:   if (tx_s) nxt = ST_RXW;
         ST_RXW: begin
            if (!tx_s)     nxt = ST_DELAY;
            else if (rx_s) nxt = ST_UP;
         end
         ST_UP:    if (!tx_s || !rx_s) nxt = ST_DELAY;
         default:  nxt = ST_DELAY;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_DELAY;
         cnt      <= '0;
         xcvr_q   <= 1'b0;
         tx_cfg_q <= 1'b0;
         rx_cfg_q <= 1'b0;
      end else begin
         state    <= nxt;
         cnt      <= (state == ST_DELAY && nxt == ST_DELAY) ? cnt + 1'b1 : '0;
         xcvr_q   <= (nxt != ST_DELAY);
         tx_cfg_q <= (nxt == ST_RXW) || (nxt == ST_UP);
         rx_cfg_q <= (nxt == ST_UP);
      end
   end

   assign xcvr_rst_n   = xcvr_q;
   assign tx_cfg_rst_n = tx_cfg_q;
   assign rx_cfg_rst_n = rx_cfg_q;

   // R3
   tx_cfg_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tx_cfg_q) |-> $past(tx_s) && $past(xcvr_q));
   // R5
   rx_after_tx_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_cfg_q |-> tx_cfg_q);
   // R9
   tx_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_cfg_q && !tx_s) |=> (!tx_cfg_q && !rx_cfg_q && !xcvr_q));
   // R9
   rx_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_cfg_q && !rx_s) |=> (!rx_cfg_q && !xcvr_q));
endmodule

// File: rtl/lrs_sysref.sv
module lrs_sysref (
   input  logic clk,
   input  logic rst_n,
   input  logic tx_live,
   output logic sysref,
   output logic done
);
   logic sent, pulse_q, done_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sent    <= 1'b0;
         pulse_q <= 1'b0;
         done_q  <= 1'b0;
      end else begin
         pulse_q <= tx_live && !sent;
         sent    <= sent || tx_live;
         done_q  <= done_q || pulse_q;
      end
   end

   assign sysref = pulse_q;
   assign done   = done_q;

   // R7
   sysref_one_cyc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pulse_q |=> !pulse_q);
   // R7
   sysref_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pulse_q |-> tx_live);
   // R8
   done_after_sysref_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done_q) |-> $past(pulse_q));
   // R8
   done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |=> done_q);
endmodule

// File: rtl/link_reset_seq.sv
module link_reset_seq #(
   parameter int DLY_CYC     = 5,
   parameter int SYNC_STAGES = 2,
   parameter int RST_STAGES  = 2,
   parameter int LINK_STAGES = 1
) (
   input  logic sys_clk,
   input  logic link_clk,
   input  logic glb_rst_n,
   input  logic tx_ready,
   input  logic rx_ready,
   output logic xcvr_rst_n,
   output logic tx_cfg_rst_n,
   output logic tx_link_rst_n,
   output logic rx_cfg_rst_n,
   output logic rx_link_rst_n,
   output logic sysref,
   output logic seq_done
);
   if (DLY_CYC < 1) begin : g_bad_dly
      $error("link_reset_seq: DLY_CYC must be at least 1");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("link_reset_seq: SYNC_STAGES must be at least 2");
   end
   if (RST_STAGES < 1 || LINK_STAGES < 1) begin : g_bad_rst
      $error("link_reset_seq: reset stage counts must be at least 1");
   end

   logic sys_rst_n, tx_s, rx_s;

   lrs_sync #(.STAGES(RST_STAGES)) u_sys_rst (
      .clk(sys_clk), .rst_n(glb_rst_n), .d(1'b1), .q(sys_rst_n));

   lrs_sync #(.STAGES(SYNC_STAGES)) u_tx_rdy (
      .clk(sys_clk), .rst_n(sys_rst_n), .d(tx_ready), .q(tx_s));

   lrs_sync #(.STAGES(SYNC_STAGES)) u_rx_rdy (
      .clk(sys_clk), .rst_n(sys_rst_n), .d(rx_ready), .q(rx_s));

   lrs_fsm #(.DLY_CYC(DLY_CYC)) u_fsm (
      .clk(sys_clk), .rst_n(sys_rst_n), .tx_s(tx_s), .rx_s(rx_s),
      .xcvr_rst_n(xcvr_rst_n), .tx_cfg_rst_n(tx_cfg_rst_n),
      .rx_cfg_rst_n(rx_cfg_rst_n));

   lrs_sync #(.STAGES(LINK_STAGES)) u_tx_link (
      .clk(link_clk), .rst_n(tx_cfg_rst_n), .d(1'b1), .q(tx_link_rst_n));

   lrs_sync #(.STAGES(LINK_STAGES)) u_rx_link (
      .clk(link_clk), .rst_n(rx_cfg_rst_n), .d(1'b1), .q(rx_link_rst_n));

   lrs_sysref u_sysref (
      .clk(link_clk), .rst_n(rx_link_rst_n), .tx_live(tx_link_rst_n),
      .sysref(sysref), .done(seq_done));

   // R4
   tx_link_order_chk: assert property (@(posedge link_clk) disable iff (!glb_rst_n)
      $rose(tx_link_rst_n) |-> tx_cfg_rst_n);
   // R6
   rx_link_order_chk: assert property (@(posedge link_clk) disable iff (!glb_rst_n)
      rx_link_rst_n |-> tx_link_rst_n);
endmodule

// File: tb/sim_link_reset_seq.sv
module sim_link_reset_seq;
   localparam int DLY = 5;

   logic sys_clk = 1'b0, link_clk = 1'b0;
   logic glb_rst_n = 1'b0, tx_ready = 1'b0, rx_ready = 1'b0;
   logic xcvr_rst_n, tx_cfg_rst_n, tx_link_rst_n, rx_cfg_rst_n, rx_link_rst_n;
   logic sysref, seq_done;

   int errors = 0, checks = 0;
   int tx_mis = 0, rx_mis = 0, sr_cnt = 0, sr_bad = 0, order_bad = 0;

   always #10 sys_clk = ~sys_clk;
   initial begin
      #3;
      forever #8 link_clk = ~link_clk;
   end

   link_reset_seq #(.DLY_CYC(DLY)) u0 (
      .sys_clk(sys_clk), .link_clk(link_clk), .glb_rst_n(glb_rst_n),
      .tx_ready(tx_ready), .rx_ready(rx_ready), .xcvr_rst_n(xcvr_rst_n),
      .tx_cfg_rst_n(tx_cfg_rst_n), .tx_link_rst_n(tx_link_rst_n),
      .rx_cfg_rst_n(rx_cfg_rst_n), .rx_link_rst_n(rx_link_rst_n),
      .sysref(sysref), .seq_done(seq_done));

   // link-clock monitor: link resets follow config resets seen before the edge
   initial begin
      logic tc, rc, prev_sr;
      prev_sr = 1'b0;
      forever begin
         @(posedge link_clk);
         tc = tx_cfg_rst_n;
         rc = rx_cfg_rst_n;
         #1;
         if (tx_link_rst_n !== tc) tx_mis++;
         if (rx_link_rst_n !== rc) rx_mis++;
         if (sysref === 1'b1) begin
            sr_cnt++;
            if (!(tx_link_rst_n && rx_link_rst_n)) sr_bad++;
            if (prev_sr) sr_bad++;
         end
         prev_sr = sysref;
      end
   end

   always @(negedge sys_clk)
      if (rx_cfg_rst_n === 1'b1 && tx_link_rst_n !== 1'b1) order_bad++;

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic wait_done(output int ok);
      ok = 0;
      for (int i = 0; i < 300; i++) begin
         @(negedge sys_clk);
         if (seq_done === 1'b1) begin ok = 1; break; end
      end
   endtask

   task automatic start_reset(input logic tx0, input logic rx0);
      int n;
      glb_rst_n = 1'b0;
      tx_ready = tx0;
      rx_ready = rx0;
      repeat (4) @(negedge sys_clk);
      // R1
      chk("R1 all outputs in reset", {25'd0, xcvr_rst_n, tx_cfg_rst_n, tx_link_rst_n,
          rx_cfg_rst_n, rx_link_rst_n, sysref, seq_done}, 0);
      sr_cnt = 0; sr_bad = 0; tx_mis = 0; rx_mis = 0; order_bad = 0;
      glb_rst_n = 1'b1;
      n = 0;
      while (xcvr_rst_n !== 1'b1 && n < 100) begin
         @(posedge sys_clk); #1; n++;
      end
      // R2
      chk("R2 delay not shorter than DLY_CYC", int'(n >= DLY && n < 100), 1);
   endtask

   task automatic t_tx_first();
      int ok;
      start_reset(1'b0, 1'b0);
      repeat (10) @(negedge sys_clk);
      // R3
      chk("R3 tx cfg held without tx_ready", int'(tx_cfg_rst_n), 0);
      tx_ready = 1'b1;
      repeat (8) @(negedge sys_clk);
      // R3
      chk("R3 tx cfg released", int'(tx_cfg_rst_n), 1);
      // R4
      chk("R4 tx link released", int'(tx_link_rst_n), 1);
      repeat (10) @(negedge sys_clk);
      // R5
      chk("R5 rx cfg held without rx_ready", int'(rx_cfg_rst_n), 0);
      rx_ready = 1'b1;
      wait_done(ok);
      chk("R8 done reached", ok, 1);
      repeat (20) @(negedge sys_clk);
      // R7
      chk("R7 single sysref", sr_cnt, 1);
      chk("R7 sysref width and timing", sr_bad, 0);
      // R8
      chk("R8 done held", int'(seq_done), 1);
      // R4
      chk("R4 tx link edge alignment", tx_mis, 0);
      // R6
      chk("R6 rx link edge alignment", rx_mis, 0);
   endtask

   task automatic t_rx_early();
      int ok;
      start_reset(1'b0, 1'b1);
      repeat (12) @(negedge sys_clk);
      // R5
      chk("R5 early rx_ready ignored", int'({tx_cfg_rst_n, rx_cfg_rst_n}), 0);
      tx_ready = 1'b1;
      wait_done(ok);
      chk("R8 done after rx-first", ok, 1);
      repeat (5) @(negedge sys_clk);
      chk("R5 rx never ahead of tx link", order_bad, 0);
      chk("R7 single sysref rx-first", sr_cnt, 1);
      chk("R6 rx link alignment rx-first", rx_mis, 0);
   endtask

   task automatic t_drop(input logic drop_tx);
      int ok;
      if (drop_tx) tx_ready = 1'b0; else rx_ready = 1'b0;
      repeat (4) @(negedge sys_clk);
      // R9
      chk(drop_tx ? "R9 tx drop resets all" : "R9 rx drop resets all",
          int'({xcvr_rst_n, tx_cfg_rst_n, tx_link_rst_n, rx_cfg_rst_n,
                rx_link_rst_n, seq_done}), 0);
      sr_cnt = 0;
      tx_ready = 1'b1;
      rx_ready = 1'b1;
      wait_done(ok);
      chk("R9 sequence restarts", ok, 1);
      repeat (5) @(negedge sys_clk);
      chk("R9 fresh single sysref", sr_cnt, 1);
   endtask

   task automatic t_glb_mid();
      @(negedge sys_clk);
      #3;
      glb_rst_n = 1'b0;
      #1;
      // R1
      chk("R1 async assertion mid-run", int'({xcvr_rst_n, tx_cfg_rst_n, tx_link_rst_n,
          rx_cfg_rst_n, rx_link_rst_n, seq_done}), 0);
   endtask

   initial begin
      #(20 * 150000);
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      t_tx_first();
      t_drop(1'b0);
      t_drop(1'b1);
      t_glb_mid();
      t_rx_early();
      t_glb_mid();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule